// File: doc/BRIEF.md
# Console Terminal Register Interface

This block is the register face of a console serial port, reached by the processor through four register selects. The receive half accepts characters from a one-cycle valid input and latches each one, together with its error flags, in a 16-bit receive word. It then sets a completion flag and, if enabled, requests an interrupt. The transmit half takes a byte written by the processor and offers it on a valid/ready output handshake. It reports completion once the far side accepts that byte.

Software sees a control register and a data register on each side. Each control register carries a completion flag that software cannot write and an interrupt enable that it can write. Reading the receive data register has side effects: it consumes the character and clears its error flags. A line break is stored as a composite error word and can also raise a one-cycle halt request. Baud generation, bit-level shifting and interrupt vectoring sit outside the block.

Top module: `cons_port`

## Requirements
- R1: After reset, receive DONE and IE are clear, transmit DONE is set and transmit IE is clear, both interrupt requests are low, `tx_valid` is low and `halt_req` is low.
- R2: Register select 0 is the receive control register and select 2 is the transmit control register. Both read DONE at bit 7 and IE at bit 6, with every other bit zero. A write changes only IE, and bit 7 of the write data is ignored.
- R3: A cycle with `rx_valid` high and `rx_brk` low loads the character into bits 7:0 of the receive word (select 1) and sets receive DONE on the next cycle. If receive IE is set, it also raises `rx_irq`.
- R4: While `seven_bit` is high, bit 7 is forced to zero in received characters and in bytes written for transmit.
- R5: If a character arrives while receive DONE is still set and the receive word is not being read in that cycle, bits 15 (error) and 14 (overrun) of the new receive word are set.
- R6: A cycle with `rx_valid` and `rx_brk` high loads the receive word with bits 15, 13 and 10 set and the character bits zero (0xA400 when no overrun applies), and sets receive DONE. If `halt_en` is high in that cycle, `halt_req` is high for exactly the following cycle.
- R7: A read strobe on select 1 returns the full receive word in the same cycle. From the next cycle receive DONE is clear, bits 15:8 are zero and bits 7:0 are unchanged.
- R8: Writing a control register with bit 6 clear drops that side's interrupt request on the next cycle.
- R9: Writing a control register with bit 6 set, while that side's DONE is set and its IE is clear, raises that side's interrupt request on the next cycle.
- R10: A write to select 3 stores the low 8 bits of the write data and clears transmit DONE. From the next cycle it drives `tx_valid` high with that byte on `tx_char`.
- R11: While `tx_ready` is low, `tx_valid` and `tx_char` hold and transmit DONE stays clear. After a cycle with both `tx_valid` and `tx_ready` high, `tx_valid` falls and transmit DONE is set. If transmit IE is set, `tx_irq` rises as well.
- R12: Select 3 reads as zero. A write to select 1 and a read strobe on selects 0, 2 or 3 leave all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seven_bit | input | 1 | Seven-bit character mode |
| reg_sel | input | 2 | Register select (0 rx control, 1 rx data, 2 tx control, 3 tx data) |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for the selected register |
| rx_valid | input | 1 | Received character or break present this cycle |
| rx_char | input | 8 | Received character |
| rx_brk | input | 1 | The arrival is a line break |
| halt_en | input | 1 | Permits a break to request a halt |
| halt_req | output | 1 | One-cycle halt request |
| tx_valid | output | 1 | Transmit byte offered |
| tx_char | output | 8 | Transmit byte |
| tx_ready | input | 1 | Output side accepts the byte |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The case hardest to reach from the ports is a control write that sets IE while DONE is already set and IE is still clear. On the receive side this requires an arrival that occurs with interrupts disabled. On the transmit side it requires a completion that lands before IE is written. The directed sequence first clears the enable, lets a character arrive or a transfer drain, and then sets the enable. It also queues a second character behind an unread one to force overrun. A long randomized phase then mixes strobes, arrivals, breaks and stalls, and checks every output each cycle against a behavioural model.

// File: rtl/cons_pkg.sv
`timescale 1ns/1ps
package cons_pkg;
    localparam int WORD_W = 16;
    localparam int CHAR_W = 8;
    localparam int SEL_W  = 2;

    // control register bit positions (software visible)
    localparam int DONE_POS = 7;
    localparam int IE_POS   = 6;
    // receive word flag positions
    localparam int ERR_POS  = 15;
    localparam int OVR_POS  = 14;
    localparam int FRM_POS  = 13;
    localparam int BRK_POS  = 10;

    typedef enum logic [SEL_W-1:0] {
        SEL_RX_CTL = 2'd0,
        SEL_RX_DAT = 2'd1,
        SEL_TX_CTL = 2'd2,
        SEL_TX_DAT = 2'd3
    } sel_e;

    typedef struct packed {
        logic              done;
        logic              ie;
        logic              irq;
        logic              halt;
        logic [WORD_W-1:0] word;
    } rx_state_t;

    typedef struct packed {
        logic              done;
        logic              ie;
        logic              irq;
        logic              busy;
        logic [CHAR_W-1:0] data;
    } tx_state_t;

    function automatic logic [CHAR_W-1:0] fold_char(input logic [CHAR_W-1:0] c,
                                                    input logic seven);
        fold_char = c;
        if (seven) fold_char[CHAR_W-1] = 1'b0;
    endfunction
endpackage

// File: rtl/cons_rx.sv
`timescale 1ns/1ps
module cons_rx
    import cons_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seven_bit,
    input  logic              ctl_wr,
    input  logic              ie_in,
    input  logic              dat_rd,
    input  logic              in_valid,
    input  logic              in_brk,
    input  logic [CHAR_W-1:0] in_char,
    input  logic              halt_en,
    output logic              done,
    output logic              ie,
    output logic              irq,
    output logic              halt,
    output logic [WORD_W-1:0] word
);
    rx_state_t st_d, st_q;

    always_comb begin
        logic [WORD_W-1:0] w_d;
        st_d      = st_q;
        st_d.halt = 1'b0;
        w_d       = '0;

        if (ctl_wr) begin
            if (!ie_in) st_d.irq = 1'b0;
            else if (st_q.done && !st_q.ie) st_d.irq = 1'b1;
            st_d.ie = ie_in;
        end

        if (dat_rd) begin
            st_d.done                = 1'b0;
            st_d.word[WORD_W-1:CHAR_W] = '0;
        end

        if (in_valid) begin
            if (in_brk) begin
                w_d[ERR_POS] = 1'b1;
                w_d[FRM_POS] = 1'b1;
                w_d[BRK_POS] = 1'b1;
            end else begin
                w_d[CHAR_W-1:0] = fold_char(in_char, seven_bit);
            end
            if (st_q.done && !dat_rd) begin
                w_d[ERR_POS] = 1'b1;
                w_d[OVR_POS] = 1'b1;
            end
            st_d.word = w_d;
            st_d.done = 1'b1;
            if (st_d.ie) st_d.irq = 1'b1;
            if (in_brk && halt_en) st_d.halt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;
    assign ie   = st_q.ie;
    assign irq  = st_q.irq;
    assign halt = st_q.halt;
    assign word = st_q.word;
endmodule

// File: rtl/cons_tx.sv
`timescale 1ns/1ps
module cons_tx
    import cons_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seven_bit,
    input  logic              ctl_wr,
    input  logic              ie_in,
    input  logic              dat_wr,
    input  logic [CHAR_W-1:0] wr_char,
    input  logic              out_ready,
    output logic              done,
    output logic              ie,
    output logic              irq,
    output logic              busy,
    output logic [CHAR_W-1:0] data
);
    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        if (ctl_wr) begin
            if (!ie_in) st_d.irq = 1'b0;
            else if (st_q.done && !st_q.ie) st_d.irq = 1'b1;
            st_d.ie = ie_in;
        end

        // a stalled transfer simply stays busy and is offered again
        if (st_q.busy && out_ready) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            if (st_d.ie) st_d.irq = 1'b1;
        end

        if (dat_wr) begin
            st_d.data = fold_char(wr_char, seven_bit);
            st_d.done = 1'b0;
            st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.done <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign done = st_q.done;
    assign ie   = st_q.ie;
    assign irq  = st_q.irq;
    assign busy = st_q.busy;
    assign data = st_q.data;
endmodule

// File: rtl/cons_rdmux.sv
`timescale 1ns/1ps
module cons_rdmux
    import cons_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic              rx_done,
    input  logic              rx_ie,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              tx_done,
    input  logic              tx_ie,
    output logic [WORD_W-1:0] rd_data
);
    always_comb begin
        rd_data = '0;
        case (sel)
            SEL_RX_CTL: begin
                rd_data[DONE_POS] = rx_done;
                rd_data[IE_POS]   = rx_ie;
            end
            SEL_RX_DAT: rd_data = rx_word;
            SEL_TX_CTL: begin
                rd_data[DONE_POS] = tx_done;
                rd_data[IE_POS]   = tx_ie;
            end
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cons_port.sv
`timescale 1ns/1ps
module cons_port
    import cons_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seven_bit,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_brk,
    input  logic              halt_en,
    output logic              halt_req,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_char,
    input  logic              tx_ready,
    output logic              rx_irq,
    output logic              tx_irq
);
    logic rx_ctl_wr, rx_dat_rd, tx_ctl_wr, tx_dat_wr;
    logic rx_done_w, rx_ie_w, tx_done_w, tx_ie_w;
    logic [WORD_W-1:0] rx_word_w;
    logic unused_wr_bits;

    assign rx_ctl_wr = wr_en && (reg_sel == SEL_RX_CTL);
    assign rx_dat_rd = rd_en && (reg_sel == SEL_RX_DAT);
    assign tx_ctl_wr = wr_en && (reg_sel == SEL_TX_CTL);
    assign tx_dat_wr = wr_en && (reg_sel == SEL_TX_DAT);
    assign unused_wr_bits = ^wr_data[WORD_W-1:CHAR_W];

    cons_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .seven_bit(seven_bit),
        .ctl_wr   (rx_ctl_wr),
        .ie_in    (wr_data[IE_POS]),
        .dat_rd   (rx_dat_rd),
        .in_valid (rx_valid),
        .in_brk   (rx_brk),
        .in_char  (rx_char),
        .halt_en  (halt_en),
        .done     (rx_done_w),
        .ie       (rx_ie_w),
        .irq      (rx_irq),
        .halt     (halt_req),
        .word     (rx_word_w)
    );

    cons_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .seven_bit(seven_bit),
        .ctl_wr   (tx_ctl_wr),
        .ie_in    (wr_data[IE_POS]),
        .dat_wr   (tx_dat_wr),
        .wr_char  (wr_data[CHAR_W-1:0]),
        .out_ready(tx_ready),
        .done     (tx_done_w),
        .ie       (tx_ie_w),
        .irq      (tx_irq),
        .busy     (tx_valid),
        .data     (tx_char)
    );

    cons_rdmux u_rdmux (
        .sel    (reg_sel),
        .rx_done(rx_done_w),
        .rx_ie  (rx_ie_w),
        .rx_word(rx_word_w),
        .tx_done(tx_done_w),
        .tx_ie  (tx_ie_w),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/cons_port_chk.sv
`timescale 1ns/1ps
module cons_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] reg_sel,
    input logic       rd_en,
    input logic       wr_en,
    input logic [15:0] wr_data,
    input logic       rx_valid,
    input logic       rx_brk,
    input logic       halt_en,
    input logic       halt_req,
    input logic       tx_valid,
    input logic [7:0] tx_char,
    input logic       tx_ready,
    input logic       rx_irq,
    input logic       tx_irq,
    input logic       rx_done,
    input logic       tx_done
);
    logic tx_dat_wr;
    assign tx_dat_wr = wr_en && (reg_sel == 2'd3);

    AST_RX_ARRIVE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> rx_done); // R3
    AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> $past(rx_valid && rx_brk && halt_en)); // R6
    AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_sel == 2'd1 && !rx_valid) |=> !rx_done); // R7
    AST_RX_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd0 && !wr_data[6]) |=> !rx_irq); // R8
    AST_TX_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd2 && !wr_data[6]) |=> !tx_irq); // R8
    AST_TX_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !tx_done); // R10
    AST_TX_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !tx_dat_wr) |=> (tx_valid && $stable(tx_char))); // R11
    AST_TX_ACCEPT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !tx_dat_wr) |=> (!tx_valid && tx_done)); // R11
endmodule

bind cons_port cons_port_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_sel (reg_sel),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rx_valid(rx_valid),
    .rx_brk  (rx_brk),
    .halt_en (halt_en),
    .halt_req(halt_req),
    .tx_valid(tx_valid),
    .tx_char (tx_char),
    .tx_ready(tx_ready),
    .rx_irq  (rx_irq),
    .tx_irq  (tx_irq),
    .rx_done (rx_done_w),
    .tx_done (tx_done_w)
);

// File: tb/cons_port_bench.sv
`timescale 1ns/1ps
module cons_port_bench;
    localparam int WD_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seven_bit = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] rd_data;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_char = 8'h0;
    logic        rx_brk = 1'b0;
    logic        halt_en = 1'b0;
    logic        halt_req;
    logic        tx_valid;
    logic [7:0]  tx_char;
    logic        tx_ready = 1'b0;
    logic        rx_irq;
    logic        tx_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cons_port u_cons_port (
        .clk(clk), .rst_n(rst_n), .seven_bit(seven_bit), .reg_sel(reg_sel),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .rx_valid(rx_valid), .rx_char(rx_char), .rx_brk(rx_brk),
        .halt_en(halt_en), .halt_req(halt_req), .tx_valid(tx_valid),
        .tx_char(tx_char), .tx_ready(tx_ready), .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    // ---------------- behavioural reference model ----------------
    bit          e_rx_done = 0, e_rx_ie = 0, e_rx_irq = 0, e_halt = 0;
    int          e_rx_word = 0;
    bit          e_tx_done = 1, e_tx_ie = 0, e_tx_irq = 0;
    logic [7:0]  e_txq[$];

    function automatic int squash(int c, bit seven);
        return seven ? (c & 'h7F) : (c & 'hFF);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            e_rx_done = 0; e_rx_ie = 0; e_rx_irq = 0; e_halt = 0; e_rx_word = 0;
            e_tx_done = 1; e_tx_ie = 0; e_tx_irq = 0; e_txq.delete();
        end else begin
            bit rdb;
            bit overrun;
            int nw;
            rdb = rd_en && reg_sel == 2'd1;
            overrun = e_rx_done && !rdb;
            e_halt = 0;
            if (wr_en && reg_sel == 2'd0) begin
                if (wr_data[6] && e_rx_done && !e_rx_ie) e_rx_irq = 1;
                if (!wr_data[6]) e_rx_irq = 0;
                e_rx_ie = wr_data[6];
            end
            if (rdb) begin e_rx_done = 0; e_rx_word = e_rx_word & 'hFF; end
            if (rx_valid) begin
                nw = rx_brk ? 'hA400 : squash(int'(rx_char), seven_bit);
                if (overrun) nw = nw | 'hC000;
                e_rx_word = nw;
                e_rx_done = 1;
                if (e_rx_ie) e_rx_irq = 1;
                if (rx_brk && halt_en) e_halt = 1;
            end
            if (wr_en && reg_sel == 2'd2) begin
                if (wr_data[6] && e_tx_done && !e_tx_ie) e_tx_irq = 1;
                if (!wr_data[6]) e_tx_irq = 0;
                e_tx_ie = wr_data[6];
            end
            if (e_txq.size() > 0 && tx_ready) begin
                void'(e_txq.pop_front());
                e_tx_done = 1;
                if (e_tx_ie) e_tx_irq = 1;
            end
            if (wr_en && reg_sel == 2'd3) begin
                e_txq.delete();
                e_txq.push_back(8'(squash(int'(wr_data), seven_bit)));
                e_tx_done = 0;
            end
        end
    end

    function automatic logic [15:0] e_rd(logic [1:0] s);
        case (s)
            2'd0: return {8'h0, e_rx_done, e_rx_ie, 6'h0};
            2'd1: return 16'(e_rx_word);
            2'd2: return {8'h0, e_tx_done, e_tx_ie, 6'h0};
            default: return 16'h0;
        endcase
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2/R7 rd_data", rd_data, e_rd(reg_sel));
            check("R3 rx_irq", {15'h0, rx_irq}, {15'h0, e_rx_irq});
            check("R11 tx_irq", {15'h0, tx_irq}, {15'h0, e_tx_irq});
            check("R10 tx_valid", {15'h0, tx_valid}, {15'h0, e_txq.size() > 0});
            check("R6 halt_req", {15'h0, halt_req}, {15'h0, e_halt});
            if (e_txq.size() > 0) check("R10 tx_char", {8'h0, tx_char}, {8'h0, e_txq[0]});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [1:0] s, logic [15:0] d);
        reg_sel = s; wr_data = d; wr_en = 1'b1;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic peek(logic [1:0] s, output logic [15:0] v);
        reg_sel = s; #1; v = rd_data;
    endtask

    task automatic rdbuf(output logic [15:0] v);
        reg_sel = 2'd1; rd_en = 1'b1; #0.5; v = rd_data;
        cyc();
        rd_en = 1'b0;
    endtask

    task automatic rxin(logic [7:0] c, logic b);
        rx_char = c; rx_brk = b; rx_valid = 1'b1;
        cyc();
        rx_valid = 1'b0; rx_brk = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(WD_CYCLES * 5.0);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            finished = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] keep;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cyc();

        // R1 reset state
        peek(2'd0, v); check("R1 rx ctl", v, 16'h0000);
        peek(2'd2, v); check("R1 tx ctl", v, 16'h0080);
        check("R1 irqs/valid/halt", {12'h0, rx_irq, tx_irq, tx_valid, halt_req}, 16'h0);

        // R2 only IE writable
        wr(2'd0, 16'hFFBF); peek(2'd0, v); check("R2 done not writable", v, 16'h0000);
        wr(2'd0, 16'h0040); peek(2'd0, v); check("R2 ie write", v, 16'h0040);

        // R3 arrival
        rxin(8'h41, 1'b0);
        check("R3 rx_irq", {15'h0, rx_irq}, 16'h1);
        peek(2'd0, v); check("R3 done set", v, 16'h00C0);
        peek(2'd1, v); check("R3 char", v, 16'h0041);

        // R5 overrun
        rxin(8'h42, 1'b0);
        peek(2'd1, v); check("R5 overrun word", v, 16'hC042);

        // R7 read side effect
        rdbuf(v); check("R7 returned word", v, 16'hC042);
        peek(2'd1, v); check("R7 errors cleared", v, 16'h0042);
        peek(2'd0, v); check("R7 done cleared", v, 16'h0040);

        // R8 withdraw
        wr(2'd0, 16'h0000); check("R8 rx_irq dropped", {15'h0, rx_irq}, 16'h0);

        // R9 late enable
        rxin(8'h33, 1'b0); check("R9 no irq while disabled", {15'h0, rx_irq}, 16'h0);
        wr(2'd0, 16'h0040); check("R9 rx_irq on enable", {15'h0, rx_irq}, 16'h1);

        // R6 break
        rdbuf(v);
        halt_en = 1'b0;
        rxin(8'h00, 1'b1);
        check("R6 no halt without enable", {15'h0, halt_req}, 16'h0);
        peek(2'd1, v); check("R6 break word", v, 16'hA400);
        rdbuf(v);
        halt_en = 1'b1;
        rxin(8'h00, 1'b1);
        check("R6 halt pulse", {15'h0, halt_req}, 16'h1);
        halt_en = 1'b0;
        cyc();
        check("R6 halt one cycle", {15'h0, halt_req}, 16'h0);

        // R4 seven-bit mode
        rdbuf(v);
        seven_bit = 1'b1;
        rxin(8'hC1, 1'b0);
        peek(2'd1, v); check("R4 rx bit7 cleared", v, 16'h0041);
        wr(2'd3, 16'h01F3);
        check("R4 tx bit7 cleared", {8'h0, tx_char}, 16'h0073);
        tx_ready = 1'b1; cyc(); tx_ready = 1'b0;
        seven_bit = 1'b0;

        // R9 tx side, R10 write, R8 tx withdraw
        wr(2'd2, 16'h0040); check("R9 tx_irq on enable", {15'h0, tx_irq}, 16'h1);
        wr(2'd3, 16'h01A5);
        check("R10 tx_valid", {15'h0, tx_valid}, 16'h1);
        check("R10 tx byte", {8'h0, tx_char}, 16'h00A5);
        peek(2'd2, v); check("R10 done cleared", v, 16'h0040);
        wr(2'd2, 16'h0000); check("R8 tx_irq dropped", {15'h0, tx_irq}, 16'h0);
        wr(2'd2, 16'h0040); check("R9 no irq while busy", {15'h0, tx_irq}, 16'h0);

        // R11 stall then accept
        repeat (5) cyc();
        check("R11 held valid", {15'h0, tx_valid}, 16'h1);
        check("R11 held byte", {8'h0, tx_char}, 16'h00A5);
        peek(2'd2, v); check("R11 done clear in stall", v, 16'h0040);
        tx_ready = 1'b1; cyc(); tx_ready = 1'b0;
        check("R11 valid falls", {15'h0, tx_valid}, 16'h0);
        peek(2'd2, v); check("R11 done set", v, 16'h00C0);
        check("R11 tx_irq", {15'h0, tx_irq}, 16'h1);

        // R12 inert accesses
        peek(2'd3, v); check("R12 tx data reads zero", v, 16'h0000);
        peek(2'd1, keep);
        wr(2'd1, 16'hFFFF);
        peek(2'd1, v); check("R12 rx data write ignored", v, keep);
        peek(2'd0, keep);
        reg_sel = 2'd0; rd_en = 1'b1; cyc(); rd_en = 1'b0;
        peek(2'd0, v); check("R12 ctl read no effect", v, keep);

        // randomized mix, compared each cycle by the model
        for (int i = 0; i < 3000; i++) begin
            reg_sel   = 2'($urandom_range(0, 3));
            wr_data   = 16'($urandom);
            wr_en     = ($urandom_range(0, 9) < 3);
            rd_en     = ($urandom_range(0, 9) < 3);
            rx_valid  = ($urandom_range(0, 9) < 3);
            rx_brk    = ($urandom_range(0, 9) == 0);
            rx_char   = 8'($urandom);
            halt_en   = $urandom_range(0, 1) == 1;
            seven_bit = $urandom_range(0, 3) == 0;
            tx_ready  = $urandom_range(0, 1) == 1;
            cyc();
        end
        wr_en = 1'b0; rd_en = 1'b0; rx_valid = 1'b0; tx_ready = 1'b0;
        cyc();

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule